// File: doc/BRIEF.md
# Command-Steered Two-Wire Register Slave

This block is a write-only slave on a two-wire serial bus (SCL clock, SDA data). It sees the bus through a fast system clock: both lines pass through synchronisers and are edge-detected. The slave finds bus START and STOP conditions, shifts in bytes on the rising edges of SCL, and acknowledges by pulling SDA low for one SCL period. The SDA line is split into an input (`sda_i`) and an active-high pull-low enable (`sda_oe_o`).

After its own address with the write flag, the slave treats the next byte as a command that picks a target register. One command code selects an 8-bit frequency register and a second selects a narrow control register. The byte after the command is held in a staging register. It reaches the target only at the STOP that closes the transfer. Any transfer cut short by an early START or STOP leaves both registers as they were. An address that does not match, a read request, or an unknown command makes the slave go silent until the next START.

Top module: `cmdreg_i2c_slave`

## Requirements
- R1: After reset `freq_o` equals FREQ_RST (default 0x00), `ctrl_o` equals CTRL_RST (default 0) and `sda_oe_o` is 0.
- R2: The first byte after a START is taken MSB first. It matches when bits 7..3 are 1,0,0,1,0, bits 2 and 1 equal `addr_pins_i[1]` and `addr_pins_i[0]`, and bit 0 (the R/W flag) is 0. On a match, `sda_oe_o` is 1 from the SCL falling edge after the eighth bit until the next SCL falling edge, and 0 at all other times.
- R3: `addr_pins_i[1]` is read only while the sixth address bit is clocked in, and `addr_pins_i[0]` only while the seventh is clocked in. The pin values at any other time have no effect on the match.
- R4: An address with R/W = 1, or with any address bit that differs from the expected value, gets no acknowledge. The slave then neither acknowledges nor writes anything until the next START.
- R5: A command byte of 0x12 (frequency register) or 0x10 (control register) is acknowledged.
- R6: Any other command byte gets no acknowledge, and no later byte of that transfer is acknowledged or written.
- R7: After command 0x12, the next byte is taken MSB first and acknowledged, and it becomes `freq_o` after the following STOP.
- R8: After command 0x10, the low CTRL_W bits of the next byte (default 4) become `ctrl_o` after the following STOP. `freq_o` is left unchanged.
- R9: A STOP or START that arrives before the data byte has been fully received and acknowledged leaves `freq_o` and `ctrl_o` unchanged.
- R10: A START that arrives after an acknowledged data byte but before any STOP throws the staged byte away. A later complete transfer then writes normally.
- R11: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. SDA changes while SCL is low are data.
- R12: `sda_oe_o` only rises right after an SCL falling edge. It only falls right after an SCL falling edge, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| addr_pins_i | input | 2 | Two pin-selected low address bits |
| freq_o | output | 8 | Frequency register |
| ctrl_o | output | CTRL_W | Control register |

## Verification
The assertions run on every cycle. They check that a register output changes only two cycles after a detected STOP, and that the frequency and control registers never change in the same cycle. They also check that the pull-low enable is only active in one of the three acknowledge states, and that it switches only on SCL falling edges or bus conditions. Only the bench's bus-master scenarios can show that the address is decoded correctly, with each pin read at its own bit slot, and that the right command bytes are accepted. They also show that an aborted transfer or a repeated START leaves the register contents as they were.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
   localparam int BYTE_W = 8;
   localparam int BITCNT_W = $clog2(BYTE_W);
   localparam logic [4:0] ADDR_FIXED = 5'b10010;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
      ST_DATA, ST_DATA_ACK, ST_HOLD, ST_SKIP
   } link_state_t;

   typedef enum logic [1:0] { SEL_NONE, SEL_FREQ, SEL_CTRL } reg_sel_t;
endpackage

// File: rtl/cmdreg_bus_sync.sv
module cmdreg_bus_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic start_p,
   output logic stop_p,
   output logic rise_p,
   output logic fall_p
);
   logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
   logic scl_d, sda_d, scl_s;

   genvar g;
   generate
      for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) begin
                  scl_pipe[0] <= 1'b1;
                  sda_pipe[0] <= 1'b1;
               end else begin
                  scl_pipe[0] <= scl_i;
                  sda_pipe[0] <= sda_i;
               end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) begin
                  scl_pipe[g] <= 1'b1;
                  sda_pipe[g] <= 1'b1;
               end else begin
                  scl_pipe[g] <= scl_pipe[g-1];
                  sda_pipe[g] <= sda_pipe[g-1];
               end
         end
      end
   endgenerate

   assign scl_s = scl_pipe[SYNC_STAGES-1];
   assign sda_s = sda_pipe[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end

   assign start_p = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_p  = scl_s & scl_d & ~sda_d & sda_s;
   assign rise_p  = scl_s & ~scl_d;
   assign fall_p  = ~scl_s & scl_d;
endmodule

// File: rtl/cmdreg_link_fsm.sv
module cmdreg_link_fsm
   import cmdreg_pkg::*;
#(
   parameter logic [7:0] CMD_FREQ = 8'h12,
   parameter logic [7:0] CMD_CTRL = 8'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              start_p,
   input  logic              stop_p,
   input  logic              rise_p,
   input  logic              fall_p,
   input  logic [1:0]        addr_pins,
   output logic              sda_oe,
   output logic              commit,
   output reg_sel_t          sel,
   output logic [BYTE_W-1:0] stage,
   output link_state_t       state
);
   logic [BYTE_W-1:0]   shift_q;
   logic [BITCNT_W-1:0] cnt_q;
   logic                done_q, pin_hi_q, pin_lo_q;
   logic                accept;

   always_comb begin
      unique case (state)
         ST_ADDR: accept = (shift_q == {ADDR_FIXED, pin_hi_q, pin_lo_q, 1'b0});
         ST_CMD:  accept = (shift_q == CMD_FREQ) || (shift_q == CMD_CTRL);
         ST_DATA: accept = 1'b1;
         default: accept = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         shift_q  <= '0;
         cnt_q    <= '0;
         done_q   <= 1'b0;
         pin_hi_q <= 1'b0;
         pin_lo_q <= 1'b0;
         sda_oe   <= 1'b0;
         commit   <= 1'b0;
         sel      <= SEL_NONE;
         stage    <= '0;
      end else begin
         commit <= 1'b0;
         if (start_p) begin
            state  <= ST_ADDR;
            cnt_q  <= '0;
            done_q <= 1'b0;
            sda_oe <= 1'b0;
            sel    <= SEL_NONE;
         end else if (stop_p) begin
            commit <= (state == ST_HOLD);
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR, ST_CMD, ST_DATA: begin
                  if (rise_p) begin
                     shift_q <= {shift_q[BYTE_W-2:0], sda_s};
                     cnt_q   <= cnt_q + 1'b1;
                     if (state == ST_ADDR && cnt_q == BITCNT_W'(5)) pin_hi_q <= addr_pins[1];
                     if (state == ST_ADDR && cnt_q == BITCNT_W'(6)) pin_lo_q <= addr_pins[0];
                     if (cnt_q == BITCNT_W'(BYTE_W-1)) done_q <= 1'b1;
                  end else if (fall_p && done_q) begin
                     done_q <= 1'b0;
                     cnt_q  <= '0;
                     if (accept) begin
                        sda_oe <= 1'b1;
                        if (state == ST_ADDR) state <= ST_ADDR_ACK;
                        else if (state == ST_CMD) begin
                           state <= ST_CMD_ACK;
                           sel   <= (shift_q == CMD_FREQ) ? SEL_FREQ : SEL_CTRL;
                        end else begin
                           state <= ST_DATA_ACK;
                           stage <= shift_q;
                        end
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               ST_ADDR_ACK: if (fall_p) begin sda_oe <= 1'b0; state <= ST_CMD;  end
               ST_CMD_ACK:  if (fall_p) begin sda_oe <= 1'b0; state <= ST_DATA; end
               ST_DATA_ACK: if (fall_p) begin sda_oe <= 1'b0; state <= ST_HOLD; end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/cmdreg_regbank.sv
module cmdreg_regbank
   import cmdreg_pkg::*;
#(
   parameter int               CTRL_W   = 4,
   parameter logic [BYTE_W-1:0] FREQ_RST = '0,
   parameter logic [CTRL_W-1:0] CTRL_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  reg_sel_t          sel,
   input  logic [BYTE_W-1:0] stage,
   output logic [BYTE_W-1:0] freq_q,
   output logic [CTRL_W-1:0] ctrl_q
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         freq_q <= FREQ_RST;
         ctrl_q <= CTRL_RST;
      end else if (commit) begin
         if (sel == SEL_FREQ) freq_q <= stage;
         if (sel == SEL_CTRL) ctrl_q <= stage[CTRL_W-1:0];
      end
endmodule

// File: rtl/cmdreg_i2c_slave.sv
module cmdreg_i2c_slave
   import cmdreg_pkg::*;
#(
   parameter int          SYNC_STAGES = 2,
   parameter int          CTRL_W      = 4,
   parameter logic [7:0]  CMD_FREQ    = 8'h12,
   parameter logic [7:0]  CMD_CTRL    = 8'h10,
   parameter logic [7:0]  FREQ_RST    = 8'h00,
   parameter logic [CTRL_W-1:0] CTRL_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic [1:0]        addr_pins_i,
   output logic [7:0]        freq_o,
   output logic [CTRL_W-1:0] ctrl_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CTRL_W < 1 || CTRL_W > BYTE_W) begin : g_chk_ctrl
         $error("CTRL_W must lie in 1..8");
      end
      if (CMD_FREQ == CMD_CTRL) begin : g_chk_cmd
         $error("command codes must differ");
      end
   endgenerate

   logic        sda_s, start_p, stop_p, rise_p, fall_p, commit;
   reg_sel_t    sel;
   logic [7:0]  stage;
   link_state_t link_state;

   cmdreg_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .start_p(start_p), .stop_p(stop_p),
      .rise_p(rise_p), .fall_p(fall_p)
   );

   cmdreg_link_fsm #(.CMD_FREQ(CMD_FREQ), .CMD_CTRL(CMD_CTRL)) u_link (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .start_p(start_p),
      .stop_p(stop_p), .rise_p(rise_p), .fall_p(fall_p),
      .addr_pins(addr_pins_i), .sda_oe(sda_oe_o), .commit(commit),
      .sel(sel), .stage(stage), .state(link_state)
   );

   cmdreg_regbank #(.CTRL_W(CTRL_W), .FREQ_RST(FREQ_RST), .CTRL_RST(CTRL_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .commit(commit), .sel(sel), .stage(stage),
      .freq_q(freq_o), .ctrl_q(ctrl_o)
   );
endmodule

// File: rtl/cmdreg_i2c_slave_chk.sv
module cmdreg_i2c_slave_chk
   import cmdreg_pkg::*;
#(
   parameter int CTRL_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sda_oe,
   input logic [7:0]        freq,
   input logic [CTRL_W-1:0] ctrl,
   input logic              start_p,
   input logic              stop_p,
   input logic              fall_p,
   input link_state_t       state
);
   // R7
   freq_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(freq) |-> $past(stop_p, 2));

   // R8
   ctrl_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl) |-> $past(stop_p, 2));

   // R8
   single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!$stable(freq) && !$stable(ctrl)));

   // R2
   ack_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> (state == ST_ADDR_ACK || state == ST_CMD_ACK || state == ST_DATA_ACK));

   // R12
   ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> $past(fall_p));

   // R12
   ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe) |-> $past(fall_p || start_p || stop_p));
endmodule

bind cmdreg_i2c_slave cmdreg_i2c_slave_chk #(.CTRL_W(CTRL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .freq(freq_o), .ctrl(ctrl_o),
   .start_p(start_p), .stop_p(stop_p), .fall_p(fall_p), .state(link_state)
);

// File: tb/cmdreg_i2c_slave_tb.sv
module cmdreg_i2c_slave_tb_top;
   localparam int Q = 10;
   localparam int NV = 8;
   // {pins[1:0], address byte, command, data}
   localparam logic [25:0] VEC [NV] = '{
      {2'b00, 8'h90, 8'h12, 8'hA5},
      {2'b11, 8'h96, 8'h12, 8'h3C},
      {2'b10, 8'h94, 8'h10, 8'h0B},
      {2'b01, 8'h90, 8'h12, 8'hFF},
      {2'b00, 8'h91, 8'h12, 8'h11},
      {2'b00, 8'h98, 8'h10, 8'h07},
      {2'b00, 8'h90, 8'h13, 8'h77},
      {2'b01, 8'h92, 8'h10, 8'h86}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic [1:0] pins = 2'b00;
   logic sda_oe;
   logic [7:0] freq;
   logic [3:0] ctrl;
   wire  sda_bus = sda_m & ~sda_oe;

   int checks = 0, failures = 0;
   bit finished = 0;
   logic [7:0] mf = 8'h00;
   logic [3:0] mc = 4'h0;

   always #2 clk = ~clk;

   cmdreg_i2c_slave dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe_o(sda_oe), .addr_pins_i(pins), .freq_o(freq), .ctrl_o(ctrl)
   );

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 0; i < n; i++) begin
         sda_m = b[7-i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
      end
   endtask

   task automatic get_ack(output bit ack);
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); ack = !sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      send_bits(b, 8);
      get_ack(ack);
   endtask

   // address byte with the pins driven per bit: good value only at listed slots
   task automatic send_addr_dyn(input logic [7:0] b, input logic [1:0] good,
                                input bit good_at_slots, output bit ack);
      for (int i = 0; i < 8; i++) begin
         pins = (((i == 5) || (i == 6)) == good_at_slots) ? good : ~good;
         sda_m = b[7-i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
      end
      get_ack(ack);
   endtask

   initial begin
      bit a1, a2, a3, ea, ec;
      wq(5);
      // R1 reset state
      check("R1 freq", freq, 8'h00);
      check("R1 ctrl", ctrl, 4'h0);
      check("R1 oe", sda_oe, 1'b0);
      rst_n = 1'b1;
      wq(5);

      for (int v = 0; v < NV; v++) begin
         logic [1:0] p; logic [7:0] ad, cm, da;
         {p, ad, cm, da} = VEC[v];
         pins = p;
         bus_start();
         send_byte(ad, a1);
         send_byte(cm, a2);
         send_byte(da, a3);
         bus_stop();
         wq(6);
         ea = (ad == {5'b10010, p, 1'b0});
         ec = ea && (cm == 8'h12 || cm == 8'h10);
         if (ec) begin
            if (cm == 8'h12) mf = da; else mc = da[3:0];
         end
         check("R2 R4 address ack", a1, ea);
         check("R5 R6 command ack", a2, ec);
         check("R7 R6 data ack", a3, ec);
         check("R7 freq after stop", freq, mf);
         check("R8 ctrl after stop", ctrl, mc);
      end

      // R2 acknowledge lasts one SCL period: released after the next fall
      pins = 2'b00;
      bus_start();
      send_byte(8'h90, a1);
      check("R2 ack seen", a1, 1'b1);
      check("R2 ack released", sda_oe, 1'b0);
      bus_stop(); wq(6);

      // R3 pins correct only at their slots -> ack and write
      bus_start();
      send_addr_dyn(8'h94, 2'b10, 1'b1, a1);
      send_byte(8'h12, a2); send_byte(8'h5A, a3);
      bus_stop(); wq(6);
      mf = 8'h5A;
      check("R3 dyn pins ack", a1, 1'b1);
      check("R3 dyn pins write", freq, mf);

      // R3 pins wrong only at their slots -> no ack, no write
      bus_start();
      send_addr_dyn(8'h94, 2'b10, 1'b0, a1);
      send_byte(8'h12, a2); send_byte(8'hC3, a3);
      bus_stop(); wq(6);
      check("R3 R4 wrong slot pins nack", a1, 1'b0);
      check("R4 ignored data", a3, 1'b0);
      check("R3 freq kept", freq, mf);

      // R9 STOP in the middle of the data byte
      pins = 2'b00;
      bus_start();
      send_byte(8'h90, a1); send_byte(8'h12, a2);
      send_bits(8'h0F, 4);
      bus_stop(); wq(6);
      check("R9 stop abort freq", freq, mf);

      // R9 START in the middle of the data byte
      bus_start();
      send_byte(8'h90, a1); send_byte(8'h10, a2);
      send_bits(8'h0E, 5);
      bus_start();
      bus_stop(); wq(6);
      check("R9 start abort ctrl", ctrl, mc);

      // R10 acked data then repeated START discards staged byte; R11 restart works
      bus_start();
      send_byte(8'h90, a1); send_byte(8'h12, a2); send_byte(8'hE1, a3);
      check("R10 data acked", a3, 1'b1);
      bus_start();
      wq(4);
      check("R10 no write at restart", freq, mf);
      send_byte(8'h90, a1); send_byte(8'h10, a2); send_byte(8'h0D, a3);
      bus_stop(); wq(6);
      mc = 4'hD;
      check("R11 restart address ack", a1, 1'b1);
      check("R10 discarded freq", freq, mf);
      check("R11 R8 ctrl via restart", ctrl, mc);

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule